// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block turns four reset causes into one internal reset and a start-up sequence for a small 16-bit processor. The causes are an external pin, a software request written through the control port, a watchdog underflow and a main-oscillator stop. The pin gives a cold reset. It clears every special-function register, the processor-mode field, the enable bits and the cause record. The other three causes give a warm reset, which resets only part of the special-function registers and keeps the processor-mode field.

Every reset holds the internal reset for a fixed number of cycles. While the reset is active, the register-file clear is asserted, so the data, address, frame-base, stack, static-base and flag registers are driven to zero, and the interrupt table base too. After the release, the block fetches a 20-bit start address from memory, one byte per read, and loads it into the program counter. Only then does it let the CPU run.

The control port also sets the processor mode, enables or disables the watchdog cause, and chooses whether an oscillator stop resets the chip. A cause register reports which source started the latest reset.

Top module: `rst_seq`

## Requirements
- R1: While the pin input is low, and until the sequence that follows it ends, the block is in cold reset. `sys_rst` and `sfr_rst_all` are 1, `cpu_run` is 0, `proc_mode` is 00 and `rst_cause` is 001 (the pin code). The enable bits return to 0.
- R2: Once the pin is released, or a warm cause is accepted, `sys_rst` and `regs_clear` stay 1 for exactly HOLD_CYCLES (default 8) clock cycles.
- R3: After the hold, three byte reads are made at addresses FFFFCh, FFFFDh and FFFFEh, in that order. The program counter becomes {byte2[3:0], byte1, byte0}. `pc_load` is 1 in the first cycle of `cpu_run`.
- R4: A control write with bit 2 set starts a warm reset with cause 010. It must be made while running and while `clk_main_sel` and `clk_main_stable` are both 1. In that case the write changes no other control bit.
- R5: If either clock qualifier is 0, the same write starts no reset. Instead `sw_err` is 1 for the cycle that follows.
- R6: A `wdt_uflow` pulse starts a warm reset with cause 011 only when control bit 3 is 1. Otherwise the CPU keeps running.
- R7: An `osc_stop` pulse starts a warm reset with cause 100 only when control bit 4 is 0. Otherwise the CPU keeps running.
- R8: During a warm reset, `sfr_rst_part` is 1 and `sfr_rst_all` is 0. `proc_mode`, which is written from control bits 1:0, keeps its value. Control writes made while not running are ignored.
- R9: When causes arrive in the same cycle, the pin wins first, then the oscillator stop, then the watchdog, then software. `rst_cause` records the winner.
- R10: A vector read whose `mem_ack` is 0 is held, with `mem_req` and `mem_addr` unchanged, and `cpu_run` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pin_rst_n | input | 1 | External reset pin, active low, cold reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 5 | [1:0] processor mode, [2] software reset, [3] watchdog reset enable, [4] oscillator-stop reset disable |
| clk_main_sel | input | 1 | The CPU clock is the main clock |
| clk_main_stable | input | 1 | The main oscillator is stable |
| wdt_uflow | input | 1 | Watchdog underflow event |
| osc_stop | input | 1 | Main-oscillator stop event |
| mem_req | output | 1 | Vector read request |
| mem_addr | output | 20 | Vector read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| sys_rst | output | 1 | Internal reset |
| regs_clear | output | 1 | Drive reset values into the CPU register file |
| sfr_rst_all | output | 1 | Reset all special-function registers (cold) |
| sfr_rst_part | output | 1 | Reset the warm-reset subset of special-function registers |
| cpu_run | output | 1 | The CPU may execute |
| pc_load | output | 1 | Program counter load strobe |
| pc_value | output | 20 | Start address fetched from the vector |
| proc_mode | output | 2 | Processor-mode field |
| rst_cause | output | 3 | Latest reset source: 001 pin, 010 software, 011 watchdog, 100 oscillator stop |
| sw_err | output | 1 | A software reset was refused |

## Verification
The bench targets these cases:
- A software request made with an unqualified clock. A design that ignores the qualifiers would reset instead of flagging `sw_err`.
- Each cause with its enable bit in both states. A design with an inverted polarity on the oscillator bit or the watchdog bit would reset when it should stay quiet.
- Simultaneous causes. A wrong priority shows up as a wrong `rst_cause`.
- A cold reset after the mode has been set. The mode must return to 00, while warm resets and writes made during a reset must leave it alone.
- A stalled vector read. A design that moves on without `mem_ack` would change the address or start the CPU early.
- The hold length, checked to the exact cycle.
- The fetch order, with a different vector on each pass so that a byte in the wrong place is caught.

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int              HOLD_CYCLES = 8,
  parameter int              PC_W        = 20,
  parameter logic [PC_W-1:0] VEC_BASE    = 20'hFFFFC
) (
  input  logic            clk,
  input  logic            pin_rst_n,
  input  logic            cfg_we,
  input  logic [4:0]      cfg_wdata,
  input  logic            clk_main_sel,
  input  logic            clk_main_stable,
  input  logic            wdt_uflow,
  input  logic            osc_stop,
  output logic            mem_req,
  output logic [PC_W-1:0] mem_addr,
  input  logic            mem_ack,
  input  logic [7:0]      mem_rdata,
  output logic            sys_rst,
  output logic            regs_clear,
  output logic            sfr_rst_all,
  output logic            sfr_rst_part,
  output logic            cpu_run,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_value,
  output logic [1:0]      proc_mode,
  output logic [2:0]      rst_cause,
  output logic            sw_err
);
  localparam int VEC_BYTES = (PC_W + 7) / 8;
  localparam int CNT_W     = $clog2(HOLD_CYCLES + 1);
  localparam int BI_W      = (VEC_BYTES > 1) ? $clog2(VEC_BYTES) : 1;
  localparam logic [2:0] C_PIN = 3'b001, C_SW = 3'b010, C_WDT = 3'b011, C_OSC = 3'b100;

  typedef enum logic [1:0] {S_HOLD, S_FETCH, S_RUN} st_t;

  st_t                        st;
  logic [CNT_W-1:0]           cnt;
  logic [BI_W-1:0]            bidx;
  logic [(VEC_BYTES-1)*8-1:0] vbuf;
  logic                       cold, wdt_en, osc_nores;

  wire running = (st == S_RUN);
  wire clk_ok  = clk_main_sel & clk_main_stable;
  wire sw_hit  = running & cfg_we & cfg_wdata[2];
  wire t_osc   = running & osc_stop & ~osc_nores;
  wire t_wdt   = running & wdt_uflow & wdt_en;
  wire t_sw    = sw_hit & clk_ok;
  wire last_b  = (bidx == BI_W'(VEC_BYTES - 1));

  assign sys_rst      = (st == S_HOLD);
  assign regs_clear   = sys_rst;
  assign sfr_rst_all  = sys_rst & cold;
  assign sfr_rst_part = sys_rst & ~cold;
  assign cpu_run      = running;
  assign mem_req      = (st == S_FETCH);
  assign mem_addr     = VEC_BASE + PC_W'(bidx);

  always_ff @(posedge clk or negedge pin_rst_n) begin
    if (!pin_rst_n) begin
      st        <= S_HOLD;
      cnt       <= '0;
      bidx      <= '0;
      vbuf      <= '0;
      cold      <= 1'b1;
      rst_cause <= C_PIN;
      proc_mode <= 2'b00;
      wdt_en    <= 1'b0;
      osc_nores <= 1'b0;
      pc_value  <= '0;
      pc_load   <= 1'b0;
      sw_err    <= 1'b0;
    end else begin
      pc_load <= 1'b0;
      sw_err  <= sw_hit & ~clk_ok;
      case (st)
        S_HOLD: begin
          if (cnt == CNT_W'(HOLD_CYCLES - 1)) begin
            st   <= S_FETCH;
            cnt  <= '0;
            bidx <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_FETCH: begin
          if (mem_ack) begin
            if (last_b) begin
              pc_value <= PC_W'({mem_rdata, vbuf});
              pc_load  <= 1'b1;
              cold     <= 1'b0;
              st       <= S_RUN;
            end else begin
              vbuf[bidx*8 +: 8] <= mem_rdata;
              bidx              <= bidx + 1'b1;
            end
          end
        end
        S_RUN: begin
          if (t_osc | t_wdt | t_sw) begin
            st        <= S_HOLD;
            cnt       <= '0;
            cold      <= 1'b0;
            rst_cause <= t_osc ? C_OSC : (t_wdt ? C_WDT : C_SW);
          end else if (cfg_we) begin
            proc_mode <= cfg_wdata[1:0];
            wdt_en    <= cfg_wdata[3];
            osc_nores <= cfg_wdata[4];
          end
        end
        default: st <= S_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
  parameter int HOLD_CYCLES = 8,
  parameter int PC_W        = 20
) (
  input logic            clk,
  input logic            pin_rst_n,
  input logic            sys_rst,
  input logic            sfr_rst_all,
  input logic            cpu_run,
  input logic            mem_req,
  input logic            mem_ack,
  input logic [PC_W-1:0] mem_addr,
  input logic            pc_load,
  input logic [1:0]      proc_mode,
  input logic            wdt_uflow,
  input logic            osc_stop,
  input logic            cfg_we,
  input logic            sw_err
);
  logic [15:0] run_len;

  always_ff @(posedge clk or negedge pin_rst_n) begin
    if (!pin_rst_n)            run_len <= '0;
    else if (!sys_rst)         run_len <= '0;
    else if (run_len != 16'hFFFF) run_len <= run_len + 1'b1;
  end

  p_hold_len_r2: assert property (@(posedge clk) disable iff (!pin_rst_n)
    $fell(sys_rst) |-> (run_len == 16'(HOLD_CYCLES)));

  p_cold_mode_r1: assert property (@(posedge clk) disable iff (!pin_rst_n)
    sfr_rst_all |-> (proc_mode == 2'b00));

  p_warm_mode_r8: assert property (@(posedge clk) disable iff (!pin_rst_n)
    (sys_rst && !sfr_rst_all && $past(sys_rst)) |-> $stable(proc_mode));

  p_fetch_phase_r3: assert property (@(posedge clk) disable iff (!pin_rst_n)
    mem_req |-> (!sys_rst && !cpu_run));

  p_pc_load_r3: assert property (@(posedge clk) disable iff (!pin_rst_n)
    pc_load |-> (cpu_run && $past(mem_req)));

  p_fetch_wait_r10: assert property (@(posedge clk) disable iff (!pin_rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_quiet_run_r6: assert property (@(posedge clk) disable iff (!pin_rst_n)
    (cpu_run && !wdt_uflow && !osc_stop && !cfg_we) |=> cpu_run);

  p_sw_err_r5: assert property (@(posedge clk) disable iff (!pin_rst_n)
    sw_err |-> $past(cfg_we));
endmodule

bind rst_seq rst_seq_chk #(.HOLD_CYCLES(HOLD_CYCLES), .PC_W(PC_W)) chk_i (
  .clk(clk), .pin_rst_n(pin_rst_n), .sys_rst(sys_rst), .sfr_rst_all(sfr_rst_all),
  .cpu_run(cpu_run), .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .pc_load(pc_load), .proc_mode(proc_mode), .wdt_uflow(wdt_uflow), .osc_stop(osc_stop),
  .cfg_we(cfg_we), .sw_err(sw_err)
);

// File: tb/rst_seq_tb_top.sv
module rst_seq_tb_top;
  logic        clk = 1'b0;
  logic        pin_rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_wdata = '0;
  logic        clk_main_sel = 1'b1, clk_main_stable = 1'b1;
  logic        wdt_uflow = 1'b0, osc_stop = 1'b0;
  logic        mem_req, mem_ack, ack_en = 1'b1;
  logic [19:0] mem_addr, pc_value, vec = 20'hA1234;
  logic [7:0]  mem_rdata;
  logic        sys_rst, regs_clear, sfr_rst_all, sfr_rst_part, cpu_run, pc_load, sw_err;
  logic [1:0]  proc_mode;
  logic [2:0]  rst_cause;
  int          tests = 0, fails = 0, nrec = 0;
  logic [19:0] rec [4];

  always #10 clk = ~clk;

  rst_seq dut_i (
    .clk(clk), .pin_rst_n(pin_rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .clk_main_sel(clk_main_sel), .clk_main_stable(clk_main_stable),
    .wdt_uflow(wdt_uflow), .osc_stop(osc_stop), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .sys_rst(sys_rst), .regs_clear(regs_clear),
    .sfr_rst_all(sfr_rst_all), .sfr_rst_part(sfr_rst_part), .cpu_run(cpu_run),
    .pc_load(pc_load), .pc_value(pc_value), .proc_mode(proc_mode),
    .rst_cause(rst_cause), .sw_err(sw_err)
  );

  assign mem_ack   = mem_req & ack_en;
  assign mem_rdata = (mem_addr == 20'hFFFFC) ? vec[7:0] :
                     (mem_addr == 20'hFFFFD) ? vec[15:8] : {4'h0, vec[19:16]};

  always @(negedge clk) if (mem_req && mem_ack && nrec < 4) begin rec[nrec] = mem_addr; nrec++; end

  // kind[8:6] 1 sw, 2 wdt, 3 osc, 4 osc+wdt, 5 sw+wdt; [5] wdt_en; [4] osc_nores; [3] clk_ok; [2:0] expected cause, 0 = none
  localparam logic [8:0] ROWS [8] = '{
    {3'd1, 1'b0, 1'b0, 1'b1, 3'd2}, {3'd1, 1'b0, 1'b0, 1'b0, 3'd0},
    {3'd2, 1'b1, 1'b0, 1'b1, 3'd3}, {3'd2, 1'b0, 1'b0, 1'b1, 3'd0},
    {3'd3, 1'b0, 1'b0, 1'b1, 3'd4}, {3'd3, 1'b0, 1'b1, 1'b1, 3'd0},
    {3'd4, 1'b1, 1'b0, 1'b1, 3'd4}, {3'd5, 1'b1, 1'b0, 1'b1, 3'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [4:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  int hold_n; logic seen_part, seen_all;
  task automatic measure_hold();
    hold_n = 0; seen_part = 0; seen_all = 0;
    while (sys_rst && hold_n < 100) begin
      hold_n++; seen_part |= sfr_rst_part; seen_all |= sfr_rst_all;
      chk("R2 regs_clear", regs_clear, 1);
      @(negedge clk);
    end
  endtask

  task automatic wait_run();
    for (int k = 0; k < 60 && !cpu_run; k++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [2:0] exp_cause;
    repeat (3) @(negedge clk);
    chk("R1 sys_rst", sys_rst, 1); chk("R1 sfr_rst_all", sfr_rst_all, 1);
    chk("R1 cpu_run", cpu_run, 0); chk("R1 mode", proc_mode, 0); chk("R1 cause", rst_cause, 3'b001);
    nrec = 0;
    pin_rst_n = 1'b1;
    measure_hold();
    chk("R2 hold after pin", hold_n, 8);
    chk("R1 cold during hold", seen_all, 1);
    wait_run();
    chk("R3 cpu_run", cpu_run, 1); chk("R3 pc_load", pc_load, 1); chk("R3 pc", pc_value, 20'hA1234);
    chk("R3 reads", nrec, 3);
    chk("R3 addr0", rec[0], 20'hFFFFC); chk("R3 addr1", rec[1], 20'hFFFFD); chk("R3 addr2", rec[2], 20'hFFFFE);
    @(negedge clk);
    chk("R3 pc_load pulse", pc_load, 0);
    exp_cause = 3'b001;

    for (int i = 0; i < 8; i++) begin
      logic [8:0] r; r = ROWS[i];
      vec = 20'h1_0203 + 20'h1_1111 * i;
      cfg_write({r[4], r[5], 1'b0, 2'b10});
      clk_main_sel = r[3]; clk_main_stable = 1'b1;
      if (r[8:6] == 3'd1 || r[8:6] == 3'd5) begin cfg_we = 1'b1; cfg_wdata = {r[4], r[5], 1'b1, 2'b10}; end
      if (r[8:6] == 3'd2 || r[8:6] == 3'd4 || r[8:6] == 3'd5) wdt_uflow = 1'b1;
      if (r[8:6] == 3'd3 || r[8:6] == 3'd4) osc_stop = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; wdt_uflow = 1'b0; osc_stop = 1'b0;
      if (r[2:0] != 3'd0) begin
        // R4 R6 R7 R9: accepted cause
        chk("R4/R6/R7 reset taken", sys_rst, 1);
        measure_hold();
        chk("R2 warm hold", hold_n, 8);
        chk("R8 partial reset", {seen_part, seen_all}, 2'b10);
        wait_run();
        exp_cause = r[2:0];
        chk("R9 cause", rst_cause, exp_cause);
        chk("R8 mode kept", proc_mode, 2'b10);
        chk("R3 pc", pc_value, vec);
      end else begin
        chk("R5/R6/R7 no reset", {sys_rst, cpu_run}, 2'b01);
        if (r[8:6] == 3'd1) chk("R5 sw_err", sw_err, 1);
        repeat (3) @(negedge clk);
        chk("R5/R6/R7 still running", cpu_run, 1);
        chk("R5/R6/R7 cause unchanged", rst_cause, exp_cause);
      end
      clk_main_sel = 1'b1;
    end

    // R10 stalled fetch, and R8 writes during reset ignored
    vec = 20'h5_6789; ack_en = 1'b0;
    cfg_write(5'b01010);
    wdt_uflow = 1'b1; @(negedge clk); wdt_uflow = 1'b0;
    cfg_write(5'b01011);
    measure_hold();
    repeat (4) @(negedge clk);
    chk("R10 req held", {mem_req, cpu_run}, 2'b10);
    chk("R10 addr held", mem_addr, 20'hFFFFC);
    ack_en = 1'b1;
    wait_run();
    chk("R10 pc after stall", pc_value, 20'h5_6789);
    chk("R8 write during reset ignored", proc_mode, 2'b10);

    // R1 cold reset clears mode and cause
    @(negedge clk); pin_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 cold mode", proc_mode, 0); chk("R1 cold cause", rst_cause, 3'b001);
    chk("R1 cold all", sfr_rst_all, 1);
    pin_rst_n = 1'b1;
    wait_run();
    wdt_uflow = 1'b1; @(negedge clk); wdt_uflow = 1'b0;
    chk("R1 wdt enable cleared", {sys_rst, cpu_run}, 2'b01);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule